// File: doc/BRIEF.md
# Serial Password Programming-Mode Detector

This block decides whether an external programming station is attached. The station sends an 8-bit password over two wires: a data line and a separate serial clock. While it does so it holds a load strobe high. When it drives the strobe low, the byte it has shifted in is copied into a compare register. If the compare register equals a password fixed at build time, the block enters programming mode. On entry it raises a watchdog-disable level and sends a one-cycle request for a system reset. The reset sequencer that receives this request holds the power-up reset low for its full duration.

Programming mode lasts until the processor writes an end-of-programming bit. That write clears the compare register and sends a one-cycle request to re-arm and reload the watchdog. It also sends a second reset request. A load strobe edge that arrives while the master reset or the power-up reset is active is discarded. This stops spurious loads during power sequencing. The data, clock and strobe lines are asynchronous to the system clock, so each one passes through a synchroniser before the block uses it.

Top module: `prog_pwd_detect`

## Requirements
- R1: After reset, progMode, wdogDisable, wdogRearm and sysRstReq are all low.
- R2: A data bit is taken on each rising edge of serClk. Bits arrive most significant first. Only the last 8 bits taken are kept, so a longer stream counts by its final 8 bits, and a byte sent in the wrong bit order does not match.
- R3: Only a falling edge of loadStrobe (1 then 0) loads the compare register. A rising edge loads nothing.
- R4: When a loaded compare value equals PASSWORD, progMode goes high and sysRstReq pulses for exactly one clock cycle.
- R5: wdogDisable is high on every cycle that progMode is high, and low otherwise.
- R6: Setting endProg while in programming mode has these effects: progMode goes low, wdogDisable goes low, and wdogRearm and sysRstReq each pulse once in the same cycle.
- R7: Leaving programming mode clears the compare register. Without a new load, progMode does not return high.
- R8: A falling edge of loadStrobe is ignored while mstrRst or purActive is high.
- R9: A loaded value that does not equal PASSWORD leaves progMode low and produces no sysRstReq pulse.
- R10: Setting endProg outside programming mode has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset of the block |
| serData | input | 1 | Asynchronous serial password data |
| serClk | input | 1 | Asynchronous serial clock; a rising edge takes one bit |
| loadStrobe | input | 1 | Asynchronous strobe; a falling edge loads the compare register |
| mstrRst | input | 1 | Master reset active; gates the load strobe |
| purActive | input | 1 | Power-up reset active; gates the load strobe |
| endProg | input | 1 | End-of-programming bit written by the processor |
| progMode | output | 1 | High while in programming mode |
| wdogDisable | output | 1 | Holds the watchdogs off during programming mode |
| wdogRearm | output | 1 | One-cycle request to re-enable the watchdog and reload its default value |
| sysRstReq | output | 1 | One-cycle request for a system reset sequence |

## Verification
The hardest situation to reach is a correct password that meets a gated strobe edge. The shift register already holds the right byte, so any later ungated edge must enter programming mode, while the gated edge must not. The stimulus table sends the valid password with mstrRst, and then with purActive, held across the strobe fall, and checks that no mode entry and no reset request follow. A directed test then leaves the valid byte in the shift register after an exit. It shows that neither waiting nor a rising strobe edge re-enters the mode, and that a bare falling edge does.

// File: rtl/prog_pwd_pkg.sv
package prog_pwd_pkg;

  typedef enum logic {
    ST_NORMAL = 1'b0,
    ST_PROG   = 1'b1
  } progState_t;

  // Strobes sent from the control to the datapath
  typedef struct packed {
    logic shiftEn;
    logic loadCmp;
    logic clearCmp;
  } dpStrobe_t;

endpackage

// File: rtl/prog_pwd_sync.sv
module prog_pwd_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [STAGES-1:0][WIDTH-1:0] stageQ;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= asyncIn;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stageQ[s] <= '0;
        else       stageQ[s] <= stageQ[s-1];
      end
    end
  end

  assign syncOut = stageQ[STAGES-1];

endmodule

// File: rtl/prog_pwd_datapath.sv
module prog_pwd_datapath
  import prog_pwd_pkg::*;
#(
  parameter int               PWD_W    = 8,
  parameter logic [PWD_W-1:0] PASSWORD = 8'hB6
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      dataBit,
  input  dpStrobe_t strobe,
  output logic      matchNow
);

  logic [PWD_W-1:0] shiftReg;
  logic [PWD_W-1:0] cmpReg;
  logic             cmpValid;

  // MSB first: older bits move toward the top of the register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              shiftReg <= '0;
    else if (strobe.shiftEn) shiftReg <= {shiftReg[PWD_W-2:0], dataBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpReg   <= '0;
      cmpValid <= 1'b0;
    end else if (strobe.clearCmp) begin
      cmpReg   <= '0;
      cmpValid <= 1'b0;
    end else if (strobe.loadCmp) begin
      cmpReg   <= shiftReg;
      cmpValid <= 1'b1;
    end
  end

  assign matchNow = cmpValid && (cmpReg == PASSWORD);

endmodule

// File: rtl/prog_pwd_ctrl.sv
module prog_pwd_ctrl
  import prog_pwd_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      clkSync,
  input  logic      strobeSync,
  input  logic      mstrRst,
  input  logic      purActive,
  input  logic      endProg,
  input  logic      matchNow,
  output dpStrobe_t strobe,
  output logic      progMode,
  output logic      wdogDisable,
  output logic      wdogRearm,
  output logic      sysRstReq
);

  progState_t state;
  logic       clkPrev;
  logic       strobePrev;
  logic       clkRise;
  logic       strobeFall;
  logic       exitNow;
  logic       enterNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      clkPrev    <= 1'b0;
      strobePrev <= 1'b0;
    end else begin
      clkPrev    <= clkSync;
      strobePrev <= strobeSync;
    end
  end

  assign clkRise    = clkSync & ~clkPrev;
  assign strobeFall = strobePrev & ~strobeSync;
  assign exitNow    = (state == ST_PROG) && endProg;
  assign enterNow   = (state == ST_NORMAL) && matchNow;

  always_comb begin
    strobe.shiftEn  = clkRise;
    strobe.loadCmp  = strobeFall && !mstrRst && !purActive;
    strobe.clearCmp = exitNow;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_NORMAL;
      wdogDisable <= 1'b0;
      wdogRearm   <= 1'b0;
      sysRstReq   <= 1'b0;
    end else begin
      wdogRearm <= 1'b0;
      sysRstReq <= 1'b0;
      if (enterNow) begin
        state       <= ST_PROG;
        wdogDisable <= 1'b1;
        sysRstReq   <= 1'b1;
      end else if (exitNow) begin
        state       <= ST_NORMAL;
        wdogDisable <= 1'b0;
        wdogRearm   <= 1'b1;
        sysRstReq   <= 1'b1;
      end
    end
  end

  assign progMode = (state == ST_PROG);

endmodule

// File: rtl/prog_pwd_detect.sv
module prog_pwd_detect
  import prog_pwd_pkg::*;
#(
  parameter int               PWD_W       = 8,
  parameter logic [PWD_W-1:0] PASSWORD    = 8'hB6,
  parameter int               SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic serData,
  input  logic serClk,
  input  logic loadStrobe,
  input  logic mstrRst,
  input  logic purActive,
  input  logic endProg,
  output logic progMode,
  output logic wdogDisable,
  output logic wdogRearm,
  output logic sysRstReq
);

  localparam int LINE_CNT = 3;

  logic [LINE_CNT-1:0] lineSync;
  dpStrobe_t           strobe;
  logic                matchNow;

  prog_pwd_sync #(
    .WIDTH  (LINE_CNT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn ({loadStrobe, serClk, serData}),
    .syncOut (lineSync)
  );

  prog_pwd_datapath #(
    .PWD_W    (PWD_W),
    .PASSWORD (PASSWORD)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .dataBit  (lineSync[0]),
    .strobe   (strobe),
    .matchNow (matchNow)
  );

  prog_pwd_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .clkSync     (lineSync[1]),
    .strobeSync  (lineSync[2]),
    .mstrRst     (mstrRst),
    .purActive   (purActive),
    .endProg     (endProg),
    .matchNow    (matchNow),
    .strobe      (strobe),
    .progMode    (progMode),
    .wdogDisable (wdogDisable),
    .wdogRearm   (wdogRearm),
    .sysRstReq   (sysRstReq)
  );

endmodule

// File: rtl/prog_pwd_checker.sv
module prog_pwd_checker (
  input logic clk,
  input logic rstN,
  input logic endProg,
  input logic progMode,
  input logic wdogDisable,
  input logic wdogRearm,
  input logic sysRstReq
);

  AST_RST_ON_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(progMode) |-> sysRstReq); // R4

  AST_RST_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    sysRstReq |=> !sysRstReq); // R4

  AST_WDOG_TRACKS_MODE: assert property (@(posedge clk) disable iff (!rstN)
    wdogDisable == progMode); // R5

  AST_REARM_ON_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    $fell(progMode) |-> (wdogRearm && sysRstReq)); // R6

  AST_EXIT_ON_END: assert property (@(posedge clk) disable iff (!rstN)
    (progMode && endProg) |=> !progMode); // R6

  AST_REARM_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    wdogRearm |-> $fell(progMode)); // R10

endmodule

bind prog_pwd_detect prog_pwd_checker u_checker (
  .clk         (clk),
  .rstN        (rstN),
  .endProg     (endProg),
  .progMode    (progMode),
  .wdogDisable (wdogDisable),
  .wdogRearm   (wdogRearm),
  .sysRstReq   (sysRstReq)
);

// File: tb/prog_pwd_detect_bench.sv
module prog_pwd_detect_bench;

  localparam logic [7:0] PWD = 8'hB6;
  localparam int NVEC = 6;
  // {byte, mstrRst, purActive, expectEntry}
  localparam logic [10:0] VEC [NVEC] = '{
    {8'hB6, 1'b0, 1'b0, 1'b1},  // R4 correct password
    {8'hB7, 1'b0, 1'b0, 1'b0},  // R9 one bit off
    {8'h6D, 1'b0, 1'b0, 1'b0},  // R2 password in reversed bit order
    {8'hB6, 1'b1, 1'b0, 1'b0},  // R8 gated by master reset
    {8'hB6, 1'b0, 1'b1, 1'b0},  // R8 gated by power-up reset
    {8'h00, 1'b0, 1'b0, 1'b0}   // R9 all zero
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serData = 1'b0, serClk = 1'b0, loadStrobe = 1'b0;
  logic mstrRst = 1'b0, purActive = 1'b0, endProg = 1'b0;
  logic progMode, wdogDisable, wdogRearm, sysRstReq;

  int checks = 0, fails = 0;
  int rstCnt = 0, rearmCnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  prog_pwd_detect #(.PASSWORD(PWD)) u_prog_pwd_detect (
    .clk(clk), .rstN(rstN), .serData(serData), .serClk(serClk),
    .loadStrobe(loadStrobe), .mstrRst(mstrRst), .purActive(purActive),
    .endProg(endProg), .progMode(progMode), .wdogDisable(wdogDisable),
    .wdogRearm(wdogRearm), .sysRstReq(sysRstReq)
  );

  always @(negedge clk) begin
    if (sysRstReq) rstCnt++;
    if (wdogRearm) rearmCnt++;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic shiftBits(input logic [15:0] v, input int n);
    loadStrobe = 1'b1;
    step(4);
    for (int i = n - 1; i >= 0; i--) begin
      serData = v[i];
      step(4);
      serClk = 1'b1;
      step(4);
      serClk = 1'b0;
      step(4);
    end
  endtask

  task automatic fallStrobe(input logic m, input logic p);
    mstrRst = m;
    purActive = p;
    step(1);
    loadStrobe = 1'b0;
    step(10);
    mstrRst = 1'b0;
    purActive = 1'b0;
    step(2);
  endtask

  task automatic endPulse();
    endProg = 1'b1;
    step(1);
    endProg = 1'b0;
    step(4);
  endtask

  initial begin
    int r0, a0;
    step(3);
    // R1 reset state
    check(progMode == 0 && wdogDisable == 0 && wdogRearm == 0 && sysRstReq == 0,
          "R1 outputs idle in reset", {progMode, wdogDisable, wdogRearm, sysRstReq}, 0);
    rstN = 1'b1;
    step(3);
    check(progMode == 0 && rstCnt == 0, "R1 idle after reset", progMode, 0);

    // R10 endProg in normal mode
    r0 = rstCnt; a0 = rearmCnt;
    endPulse();
    check(progMode == 0 && rstCnt == r0 && rearmCnt == a0 && wdogDisable == 0,
          "R10 endProg ignored in normal mode", rstCnt - r0 + rearmCnt - a0, 0);

    // Table walk
    for (int k = 0; k < NVEC; k++) begin
      logic [7:0] b;
      logic expE;
      b = VEC[k][10:3];
      expE = VEC[k][0];
      r0 = rstCnt; a0 = rearmCnt;
      shiftBits({8'h00, b}, 8);
      fallStrobe(VEC[k][2], VEC[k][1]);
      check(progMode == expE, "R4/R8/R9 mode after load", progMode, expE);
      check(rstCnt - r0 == int'(expE), "R4/R9 reset request count", rstCnt - r0, expE);
      check(wdogDisable == expE, "R5 watchdog disable level", wdogDisable, expE);
      if (expE) begin
        endPulse();
        check(progMode == 0 && wdogDisable == 0, "R6 leaves mode", progMode, 0);
        check(rearmCnt - a0 == 1, "R6 one rearm pulse", rearmCnt - a0, 1);
        check(rstCnt - r0 == 2, "R6 second reset request", rstCnt - r0, 2);
      end
    end

    // R2 longer stream: last 8 bits count
    r0 = rstCnt;
    shiftBits(16'h0AB6, 12);
    fallStrobe(1'b0, 1'b0);
    check(progMode == 1, "R2 last eight bits kept", progMode, 1);
    endPulse();
    check(progMode == 0, "R6 exit after R2 entry", progMode, 0);

    // R7 compare register cleared: no re-entry while waiting
    r0 = rstCnt;
    step(30);
    check(progMode == 0 && rstCnt == r0, "R7 no re-entry after clear", progMode, 0);

    // R3 rising strobe edge does not load (shift register still holds password)
    loadStrobe = 1'b1;
    step(12);
    check(progMode == 0, "R3 rising edge loads nothing", progMode, 0);
    fallStrobe(1'b0, 1'b0);
    check(progMode == 1, "R3 falling edge loads", progMode, 1);
    check(rstCnt - r0 == 1, "R4 single reset request", rstCnt - r0, 1);
    endPulse();
    check(progMode == 0, "R6 final exit", progMode, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule